// File: doc/BRIEF.md
# Per-Pin Interrupt Detector

This block watches a bank of input pins and raises one interrupt request when any pin meets the condition that software has chosen for it. Each pin has its own control word. A 4-bit field in that word selects the pin's mode: off, active low level, active high level, rising edge, falling edge or either edge. The pins are first passed through a two-stage synchronizer. Edges are found by comparing each synchronized level with its value one cycle earlier.

A detected condition sets a sticky per-pin flag. All flags are combined into a single registered interrupt line. Software finds the source by reading the flag word and clears the flags it has serviced by writing ones to them. Register access uses a simple single-cycle write strobe and a read strobe whose data appears one cycle later.

Top module: `pin_irq_detect`

## Requirements
- R1: During reset and right after it, every flag is 0, every pin's mode field is 0, `irq_o` is 0 and `bus_rdata` is 0.
- R2: Pin n's control word is at byte address n*4 (n = 0..31). A write stores `bus_wdata[19:16]` as the pin's mode code. A read returns that code in bits 19:16 and zeros in every other bit.
- R3: Code 0x8 flags the pin on every cycle its synchronized level is 0. Code 0xC flags it on every cycle the level is 1.
- R4: Code 0x9 flags a 0-to-1 change of the synchronized level, 0xA flags a 1-to-0 change, and 0xB flags either change. Selecting an edge mode while the pin is held steady raises no flag.
- R5: Code 0x0 and the unlisted codes 0x1–0x7 and 0xD–0xF detect nothing, so the flag of such a pin never sets.
- R6: The flag word is at address 0xA0, with bit n for pin n. Writing it clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged. A flag stays set until it is cleared this way.
- R7: When a detection and a clear hit the same flag in the same cycle, the flag stays set. A level-mode pin held at its active level therefore cannot be cleared.
- R8: `irq_o` equals the OR of all flags as they stood one cycle earlier.
- R9: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read. Addresses that are not mapped read as zero, and writes to them change nothing.
- R10: A pin change made before clock edge k sets its flag at edge k+2 and raises `irq_o` at edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pin_i | input | 32 | Asynchronous pin levels |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bound checker tests the following on every cycle:
- the reset state;
- that `irq_o` follows the previous cycle's flags;
- that flags only rise on pins with a valid mode;
- that flags persist when no clear is written;
- that unmapped reads return zero;
- that read data holds between reads.

Some behaviour only the bench scenarios can show:
- which condition each mode actually detects;
- that selecting a mode on a steady pin raises no flag;
- that a level-mode flag survives a clear;
- that an event beats a clear in the same cycle;
- the exact synchronizer latency.

A random phase compares every read and every cycle of `irq_o` against a reference model built from the requirements.

// File: rtl/pind_pkg.sv
package pind_pkg;

    typedef enum logic [2:0] {
        MODE_OFF,
        MODE_LOW,
        MODE_HIGH,
        MODE_RISE,
        MODE_FALL,
        MODE_BOTH
    } pin_mode_e;

    localparam logic [3:0] CODE_LOW  = 4'h8;
    localparam logic [3:0] CODE_RISE = 4'h9;
    localparam logic [3:0] CODE_FALL = 4'hA;
    localparam logic [3:0] CODE_BOTH = 4'hB;
    localparam logic [3:0] CODE_HIGH = 4'hC;

    // any code not listed above selects no detection
    function automatic pin_mode_e decode_mode(input logic [3:0] code);
        pin_mode_e m;
        case (code)
            CODE_LOW:  m = MODE_LOW;
            CODE_HIGH: m = MODE_HIGH;
            CODE_RISE: m = MODE_RISE;
            CODE_FALL: m = MODE_FALL;
            CODE_BOTH: m = MODE_BOTH;
            default:   m = MODE_OFF;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pind_sync.sv
module pind_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign dout = pipe_q[STAGES-1];

endmodule

// File: rtl/pind_detect.sv
module pind_detect
    import pind_pkg::*;
#(
    parameter int NPIN  = 32,
    parameter int CFG_W = 4
) (
    input  logic [NPIN-1:0][CFG_W-1:0] cfg_i,
    input  logic [NPIN-1:0]            lvl_i,
    input  logic [NPIN-1:0]            prv_i,
    output logic [NPIN-1:0]            hit_o
);

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic hit_b;
        always_comb begin
            case (decode_mode(cfg_i[g]))
                MODE_LOW:  hit_b = !lvl_i[g];
                MODE_HIGH: hit_b = lvl_i[g];
                MODE_RISE: hit_b = lvl_i[g] && !prv_i[g];
                MODE_FALL: hit_b = !lvl_i[g] && prv_i[g];
                MODE_BOTH: hit_b = lvl_i[g] ^ prv_i[g];
                default:   hit_b = 1'b0;
            endcase
        end
        assign hit_o[g] = hit_b;
    end

endmodule

// File: rtl/pind_addr_dec.sv
module pind_addr_dec #(
    parameter int             NPIN        = 32,
    parameter int             AW          = 8,
    parameter logic [AW-1:0]  FLAG_OFFSET = 8'hA0
) (
    input  logic [AW-1:0]   addr_i,
    output logic [NPIN-1:0] sel_cfg_o,
    output logic            sel_flag_o
);

    localparam int STRIDE = 4;

    for (genvar g = 0; g < NPIN; g++) begin : g_sel
        localparam logic [AW-1:0] BASE = AW'(g * STRIDE);
        assign sel_cfg_o[g] = (addr_i == BASE);
    end

    assign sel_flag_o = (addr_i == FLAG_OFFSET);

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
    import pind_pkg::*;
#(
    parameter int             NPIN        = 32,
    parameter int             AW          = 8,
    parameter int             DW          = 32,
    parameter int             SYNC_STAGES = 2,
    parameter int             FIELD_LSB   = 16,
    parameter logic [AW-1:0]  FLAG_OFFSET = 8'hA0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [31:0]   pin_i,
    output logic          irq_o
);

    localparam int CFG_W = 4;

    typedef struct packed {
        logic [NPIN-1:0][CFG_W-1:0] cfg;
        logic [NPIN-1:0]            flag;
        logic [NPIN-1:0]            prev;
        logic                       irq;
        logic [DW-1:0]              rdata;
    } state_t;

    state_t state_d, state_q;

    logic [NPIN-1:0] lvl;
    logic [NPIN-1:0] hit;
    logic [NPIN-1:0] sel_cfg;
    logic            sel_flag;
    logic [NPIN-1:0] clr_mask;
    logic [DW-1:0]   rd_val;

    pind_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_i[NPIN-1:0]),
        .dout  (lvl)
    );

    pind_detect #(.NPIN(NPIN), .CFG_W(CFG_W)) u_detect (
        .cfg_i (state_q.cfg),
        .lvl_i (lvl),
        .prv_i (state_q.prev),
        .hit_o (hit)
    );

    pind_addr_dec #(.NPIN(NPIN), .AW(AW), .FLAG_OFFSET(FLAG_OFFSET)) u_dec (
        .addr_i     (bus_addr),
        .sel_cfg_o  (sel_cfg),
        .sel_flag_o (sel_flag)
    );

    // read mux
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NPIN; i++) begin
            if (sel_cfg[i]) rd_val[FIELD_LSB +: CFG_W] = state_q.cfg[i];
        end
        if (sel_flag) rd_val[NPIN-1:0] = state_q.flag;
    end

    assign clr_mask = (bus_wr && sel_flag) ? bus_wdata[NPIN-1:0] : '0;

    // next-state
    always_comb begin
        state_d      = state_q;
        state_d.prev = lvl;
        state_d.irq  = |state_q.flag;
        for (int i = 0; i < NPIN; i++) begin
            if (bus_wr && sel_cfg[i]) state_d.cfg[i] = bus_wdata[FIELD_LSB +: CFG_W];
        end
        // a fresh detection outranks a same-cycle clear
        state_d.flag = (state_q.flag & ~clr_mask) | hit;
        if (bus_rd) state_d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign bus_rdata = state_q.rdata;
    assign irq_o     = state_q.irq;

endmodule

// File: rtl/pind_checker.sv
module pind_checker #(
    parameter int             NPIN        = 32,
    parameter int             AW          = 8,
    parameter int             DW          = 32,
    parameter logic [AW-1:0]  FLAG_OFFSET = 8'hA0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [AW-1:0]     bus_addr,
    input logic [DW-1:0]     bus_rdata,
    input logic [NPIN*4-1:0] cfg_flat,
    input logic [NPIN-1:0]   flag,
    input logic              irq
);

    localparam logic [AW-1:0] CFG_END = AW'(NPIN * 4 - 1);

    logic [NPIN-1:0] en;
    logic            unmapped;
    logic            flag_wr;

    always_comb begin
        for (int i = 0; i < NPIN; i++) begin
            en[i] = (cfg_flat[i*4 +: 4] >= 4'h8) && (cfg_flat[i*4 +: 4] <= 4'hC);
        end
    end

    assign unmapped = !(((bus_addr <= CFG_END) && (bus_addr[1:0] == 2'b00))
                        || (bus_addr == FLAG_OFFSET));
    assign flag_wr  = bus_wr && (bus_addr == FLAG_OFFSET);

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (flag == '0 && !irq && cfg_flat == '0 && bus_rdata == '0));

    p_irq_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag) |=> irq);

    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(|flag) |=> !irq);

    p_flag_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en != {NPIN{1'b1}}) |=> ((flag & ~$past(flag) & ~$past(en)) == '0));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_wr |=> ((flag & $past(flag)) == $past(flag)));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |=> (bus_rdata == '0));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

bind pin_irq_detect pind_checker #(
    .NPIN(NPIN), .AW(AW), .DW(DW), .FLAG_OFFSET(FLAG_OFFSET)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .cfg_flat  (state_q.cfg),
    .flag      (state_q.flag),
    .irq       (irq_o)
);

// File: tb/pin_irq_detect_tb.sv
module pin_irq_detect_tb;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] FLAGS = 8'hA0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pin_i = '0;
    logic        irq_o;

    int total = 0;
    int bad = 0;
    bit irq_chk = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_irq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_i(pin_i), .irq_o(irq_o)
    );

    // reference model, written from the requirements
    logic [31:0]       m_s1, m_s2, m_prev, m_flag;
    logic [31:0][3:0]  m_cfg;
    logic              m_irq;
    logic [31:0]       m_rdata;

    function automatic bit exp_hit(input logic [3:0] code, input bit cur, input bit prv);
        case (code)
            4'h8: return !cur;
            4'hC: return cur;
            4'h9: return cur && !prv;
            4'hA: return !cur && prv;
            4'hB: return cur != prv;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] v = '0;
        if (a < 8'h80 && a[1:0] == 2'b00) v[19:16] = m_cfg[a[6:2]];
        else if (a == FLAGS) v = m_flag;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_flag <= '0;
            m_cfg <= '0; m_irq <= 1'b0; m_rdata <= '0;
        end else begin
            logic [31:0] h;
            logic [31:0] c;
            for (int i = 0; i < 32; i++) h[i] = exp_hit(m_cfg[i], m_s2[i], m_prev[i]);
            c = (bus_wr && bus_addr == FLAGS) ? bus_wdata : '0;
            m_s1 <= pin_i; m_s2 <= m_s1; m_prev <= m_s2;
            m_flag <= (m_flag & ~c) | h;
            m_irq <= |m_flag;
            if (bus_wr && bus_addr < 8'h80 && bus_addr[1:0] == 2'b00)
                m_cfg[bus_addr[6:2]] <= bus_wdata[19:16];
            if (bus_rd) m_rdata <= exp_read(bus_addr);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (irq_chk) check("R8 irq", {31'b0, irq_o}, {31'b0, m_irq});
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R1 irq in reset", {31'b0, irq_o}, 32'h0);
        check("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        irq_chk = 1'b1;

        // R1: flags and mode fields cleared
        rd(FLAGS, d);  check("R1 flags after reset", d, 32'h0);
        rd(8'h14, d);  check("R1 cfg after reset", d, 32'h0);

        // R2: field placement and readback
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, d);  check("R2 cfg readback", d, 32'h000F_0000);
        rd(8'h18, d);  check("R2 neighbour untouched", d, 32'h0);
        wr(8'h14, 32'h0);

        // R3 + R7: high level on pin 3
        wr(8'h0C, 32'h000C_0000);
        pin_i[3] = 1'b1; idle(4);
        rd(FLAGS, d);  check("R3 high level sets flag", d, 32'h8);
        wr(FLAGS, 32'h8);
        rd(FLAGS, d);  check("R7 clear overridden by level", d, 32'h8);
        pin_i[3] = 1'b0; idle(4);
        wr(FLAGS, 32'h0);
        rd(FLAGS, d);  check("R6 zero write keeps flag", d, 32'h8);
        wr(FLAGS, 32'h8);
        rd(FLAGS, d);  check("R6 one write clears", d, 32'h0);
        wr(8'h0C, 32'h0);

        // R3: low level on pin 4 (pin is low)
        wr(8'h10, 32'h0008_0000); idle(2);
        rd(FLAGS, d);  check("R3 low level sets flag", d, 32'h10);
        wr(8'h10, 32'h0); wr(FLAGS, 32'hFFFF_FFFF);
        rd(FLAGS, d);  check("R6 all ones clears", d, 32'h0);

        // R4: rising on pin 7, enabled while high
        pin_i[7] = 1'b1; idle(4);
        wr(8'h1C, 32'h0009_0000); idle(3);
        rd(FLAGS, d);  check("R4 enable makes no edge", d, 32'h0);
        pin_i[7] = 1'b0; idle(4);
        rd(FLAGS, d);  check("R4 falling ignored in rise mode", d, 32'h0);
        pin_i[7] = 1'b1; idle(4);
        rd(FLAGS, d);  check("R4 rising sets flag", d, 32'h80);
        wr(8'h1C, 32'h000A_0000); wr(FLAGS, 32'h80);
        pin_i[7] = 1'b0; idle(4);
        rd(FLAGS, d);  check("R4 falling sets flag", d, 32'h80);
        wr(8'h1C, 32'h000B_0000); wr(FLAGS, 32'h80);
        pin_i[7] = 1'b1; idle(4);
        rd(FLAGS, d);  check("R4 either edge sets flag", d, 32'h80);
        wr(8'h1C, 32'h0); wr(FLAGS, 32'h80); pin_i[7] = 1'b0; idle(4);

        // R5: unlisted codes and zero detect nothing
        wr(8'h24, 32'h0005_0000); wr(8'h28, 32'h000F_0000);
        pin_i[9] = 1'b1; pin_i[10] = 1'b1; idle(4);
        pin_i[9] = 1'b0; pin_i[10] = 1'b0; idle(4);
        rd(FLAGS, d);  check("R5 unlisted codes ignored", d, 32'h0);
        wr(8'h24, 32'h0); wr(8'h28, 32'h0);

        // R9: unmapped read zero, unmapped write no effect
        rd(8'h84, d);  check("R9 unmapped read", d, 32'h0);
        wr(8'h90, 32'hFFFF_FFFF); wr(8'h02, 32'hFFFF_FFFF);
        rd(8'h00, d);  check("R9 unmapped write ignored", d, 32'h0);
        rd(FLAGS, d);  check("R9 flags unchanged", d, 32'h0);

        // R10: latency from pin to irq, pin 2 in high mode
        wr(8'h08, 32'h000C_0000);
        pin_i[2] = 1'b1;                // before edge k
        @(posedge clk); @(posedge clk); @(posedge clk); #1;
        check("R10 irq low after k+2", {31'b0, irq_o}, 32'h0);
        @(posedge clk); #1;
        check("R10 irq high after k+3", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        pin_i[2] = 1'b0; wr(8'h08, 32'h0); idle(3); wr(FLAGS, 32'hFFFF_FFFF); idle(2);

        // random phase against the model
        for (int it = 0; it < 3000; it++) begin
            int op = $urandom_range(0, 9);
            logic [3:0] codes [6] = '{4'h0, 4'h8, 4'h9, 4'hA, 4'hB, 4'hC};
            if ($urandom_range(0, 3) == 0) pin_i = $urandom;
            if (op < 2) begin
                logic [3:0] cd = ($urandom_range(0, 7) == 0) ? 4'($urandom) : codes[$urandom_range(0, 5)];
                wr(8'($urandom_range(0, 31) * 4), {12'($urandom), cd, 16'($urandom)});
            end else if (op < 4) begin
                wr(FLAGS, $urandom);
            end else if (op < 7) begin
                logic [7:0] a = ($urandom_range(0, 1) == 0) ? FLAGS : 8'($urandom);
                rd(a, d);
                check("R6 random read", d, m_rdata);
            end else begin
                @(negedge clk);
            end
        end

        irq_chk = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule